// File: doc/BRIEF.md
# Successive-Approximation Converter Controller with Read-Strobe Bus Interface

This block is the digital core of an 8-bit successive-approximation converter that hangs directly on a microprocessor bus. A read access, with chip-select and read strobe both low, starts a conversion. The same access reads out the latched result of the previous conversion. An active-low busy flag covers the whole conversion. A host can therefore stall on that flag and pick up the fresh code within one read ("slow memory" style). It can also treat the block like a ROM: one read starts the conversion, and a later read collects the result.

The conversion clock is halved internally. A conversion takes a fixed frame of 20 input clocks, which is 10 internal cycles. The first two internal cycles clear the approximation register and let the held input settle. A one-cycle hold strobe tells the external track/hold when to freeze the input. Eight MSB-first bit trials follow. Each trial drives a trial code to an external DAC and samples a single comparator decision bit. The result latch is written at the end of the frame and is placed on a data vector with an active-high output enable, which stands in for a tri-state bus. A read that arrives right after completion is served without starting another conversion. This lets a ROM-style host collect data without triggering a fresh frame.

Top module: `sar_adc_ctl`

## Requirements
- R1: A conversion starts only when the synchronized strobes change from "not both low" to "both low" while the block is idle. With strobes that change just after a rising edge, busy_n_o falls after the third following rising edge (two synchronizer stages plus one edge-detect register).
- R2: busy_n_o stays low for exactly 2*(SETTLE_ICYC+DATA_W) = 20 clock cycles per conversion and then returns high.
- R3: hold_o is high for exactly one cycle, beginning at the third rising edge after the edge at which busy_n_o fell. The input value present at that edge is the one converted. Changes made before it are tracked, and changes made after it are ignored.
- R4: dac_code_o is 0x00 from the first edge of the conversion until the trial phase begins two internal cycles in. The first trial code, 0x80, appears four cycles after busy_n_o falls.
- R5: The bits are tried MSB first. A bit is kept when cmp_i is 1, meaning held input >= DAC level, sampled at the end of its internal cycle, and is cleared otherwise. The result is straight binary 0x00..0xFF and equals the held input code.
- R6: data_oe_o is 1 only while the synchronized strobes are both low, and is 0 once they are released. data_o carries the result latch.
- R7: The result latch changes only at the edge where busy_n_o rises. A read while busy_n_o is low returns the previous result.
- R8: A read whose both-low strobes arrive within one clock period after busy_n_o rises returns the new data and starts no conversion. A read that arrives one clock later, or any later read, starts a conversion.
- R9: While idle, the internal half-rate phase stays at 0, dac_code_o holds its last value, and keeping the strobes low after completion starts nothing.
- R10: After a synchronous reset, busy_n_o = 1, hold_o = 0, data_oe_o = 0, dac_code_o = 0x00 and data_o = 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock (input clock to be halved) |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low, asynchronous to clk |
| rd_n | input | 1 | Read strobe, active low, asynchronous to clk |
| cmp_i | input | 1 | Comparator decision: 1 when held input >= DAC level |
| hold_o | output | 1 | One-cycle strobe freezing the external track/hold |
| dac_code_o | output | DATA_W | Trial code for the external DAC |
| busy_n_o | output | 1 | Low while a conversion is in progress |
| data_o | output | DATA_W | Latched conversion result |
| data_oe_o | output | 1 | Output enable for data_o (models the tri-state driver) |

## Verification
The bench builds the block with its default parameters: 8 data bits, two synchronizer stages, hold at the third edge, two settle cycles and a one-clock re-read window. With these values the 20-cycle frame is short enough to walk cycle by cycle. Every conversion is checked for its hold position, its first trial code and its busy length. The small guard window puts the blocked and the accepted re-read at adjacent falling edges, so the exact boundary of R8 is exercised. A behavioural comparator captures the input at the hold strobe. Moving the input on either side of that strobe shows which value gets converted.

// File: rtl/sar_adc_ctl_pkg.sv
package sar_adc_ctl_pkg;

  // Input-clock cycles in one conversion frame: settle cycles plus one
  // internal cycle per bit, each internal cycle being two input clocks.
  function automatic int frame_len(input int data_w, input int settle_icyc);
    return 2 * (settle_icyc + data_w);
  endfunction

  // Edges after busy release during which a new request is refused,
  // covering the synchronizer delay plus the re-read allowance.
  function automatic int guard_len(input int sync_stages, input int rearm_cyc);
    return sync_stages + rearm_cyc;
  endfunction

endpackage

// File: rtl/sar_bus_sync.sv
module sar_bus_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic rd_n,
  output logic start_req,
  output logic access_q
);

  localparam int LANES = 2;

  logic [LANES-1:0]                  pin;
  logic [LANES-1:0][SYNC_STAGES-1:0] sh_q;
  logic                              req;
  logic                              req_prev_q;

  assign pin = {cs_n, rd_n};

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) sh_q[l] <= '1;
      else     sh_q[l] <= {sh_q[l][SYNC_STAGES-2:0], pin[l]};
    end
  end

  assign req = ~sh_q[1][SYNC_STAGES-1] & ~sh_q[0][SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      req_prev_q <= 1'b0;
      access_q   <= 1'b0;
    end else begin
      req_prev_q <= req;
      access_q   <= req;
    end
  end

  assign start_req = req & ~req_prev_q;

endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer
  import sar_adc_ctl_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_EDGE   = 3,
  parameter int SETTLE_ICYC = 2,
  parameter int REARM_CYC   = 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start_req,
  output logic                      busy_q,
  output logic                      hold_q,
  output logic                      phase_q,
  output logic                      clr,
  output logic                      set_en,
  output logic [$clog2(DATA_W)-1:0] set_idx,
  output logic                      dec_en,
  output logic [$clog2(DATA_W)-1:0] dec_idx,
  output logic                      done
);

  localparam int FRAME     = frame_len(DATA_W, SETTLE_ICYC);
  localparam int CNT_W     = $clog2(FRAME + 1);
  localparam int IDX_W     = $clog2(DATA_W);
  localparam int GUARD     = guard_len(SYNC_STAGES, REARM_CYC);
  localparam int GRD_W     = $clog2(GUARD + 1);
  localparam int SET_FIRST = 2 * SETTLE_ICYC - 1;
  localparam int DEC_FIRST = 2 * SETTLE_ICYC + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [GRD_W-1:0] grd_q;

  // Step decode: odd counts close an internal cycle (phase 1).
  always_comb begin
    int c;
    int ts;
    int td;
    c       = int'(cnt_q);
    ts      = (c - SET_FIRST) / 2;
    td      = (c - DEC_FIRST) / 2;
    clr     = busy_q && (c == 0);
    set_en  = busy_q && phase_q && (c >= SET_FIRST) && (ts < DATA_W);
    dec_en  = busy_q && phase_q && (c >= DEC_FIRST) && (td < DATA_W);
    set_idx = set_en ? IDX_W'(DATA_W - 1 - ts) : '0;
    dec_idx = dec_en ? IDX_W'(DATA_W - 1 - td) : '0;
    done    = busy_q && (cnt_q == CNT_W'(FRAME - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      phase_q <= 1'b0;
      hold_q  <= 1'b0;
      grd_q   <= '0;
    end else begin
      hold_q <= busy_q && (cnt_q == CNT_W'(HOLD_EDGE - 1));
      if (grd_q != '0) grd_q <= grd_q - GRD_W'(1);
      if (!busy_q) begin
        if (start_req && (grd_q == '0)) begin
          busy_q  <= 1'b1;
          cnt_q   <= '0;
          phase_q <= 1'b0;
        end
      end else if (done) begin
        busy_q  <= 1'b0;
        cnt_q   <= '0;
        phase_q <= 1'b0;
        grd_q   <= GRD_W'(GUARD);
      end else begin
        cnt_q   <= cnt_q + CNT_W'(1);
        phase_q <= ~phase_q;
      end
    end
  end

endmodule

// File: rtl/sar_register.sv
module sar_register #(
  parameter int DATA_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clr,
  input  logic                      set_en,
  input  logic [$clog2(DATA_W)-1:0] set_idx,
  input  logic                      dec_en,
  input  logic [$clog2(DATA_W)-1:0] dec_idx,
  input  logic                      cmp,
  input  logic                      done,
  output logic [DATA_W-1:0]         trial_q,
  output logic [DATA_W-1:0]         result_q
);

  logic [DATA_W-1:0] trial_nx;

  always_comb begin
    trial_nx = trial_q;
    if (clr)                trial_nx = '0;
    if (set_en)             trial_nx[set_idx] = 1'b1;
    if (dec_en && !cmp)     trial_nx[dec_idx] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trial_q  <= '0;
      result_q <= '0;
    end else begin
      trial_q <= trial_nx;
      if (done) result_q <= trial_nx;
    end
  end

endmodule

// File: rtl/sar_adc_ctl.sv
module sar_adc_ctl
  import sar_adc_ctl_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_EDGE   = 3,
  parameter int SETTLE_ICYC = 2,
  parameter int REARM_CYC   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              cmp_i,
  output logic              hold_o,
  output logic [DATA_W-1:0] dac_code_o,
  output logic              busy_n_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);

  localparam int IDX_W = $clog2(DATA_W);

  logic             start_req;
  logic             busy_q;
  logic             div_phase;
  logic             clr;
  logic             set_en;
  logic             dec_en;
  logic             done;
  logic [IDX_W-1:0] set_idx;
  logic [IDX_W-1:0] dec_idx;

  sar_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (cs_n),
    .rd_n      (rd_n),
    .start_req (start_req),
    .access_q  (data_oe_o)
  );

  sar_sequencer #(
    .DATA_W      (DATA_W),
    .SYNC_STAGES (SYNC_STAGES),
    .HOLD_EDGE   (HOLD_EDGE),
    .SETTLE_ICYC (SETTLE_ICYC),
    .REARM_CYC   (REARM_CYC)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start_req (start_req),
    .busy_q    (busy_q),
    .hold_q    (hold_o),
    .phase_q   (div_phase),
    .clr       (clr),
    .set_en    (set_en),
    .set_idx   (set_idx),
    .dec_en    (dec_en),
    .dec_idx   (dec_idx),
    .done      (done)
  );

  sar_register #(.DATA_W(DATA_W)) u_reg (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .set_en   (set_en),
    .set_idx  (set_idx),
    .dec_en   (dec_en),
    .dec_idx  (dec_idx),
    .cmp      (cmp_i),
    .done     (done),
    .trial_q  (dac_code_o),
    .result_q (data_o)
  );

  assign busy_n_o = ~busy_q;

endmodule

// File: rtl/sar_adc_ctl_chk.sv
module sar_adc_ctl_chk
  import sar_adc_ctl_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_EDGE   = 3,
  parameter int SETTLE_ICYC = 2,
  parameter int REARM_CYC   = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              busy_n,
  input logic              hold,
  input logic [DATA_W-1:0] dac_code,
  input logic [DATA_W-1:0] data,
  input logic              phase
);

  localparam int FRAME   = frame_len(DATA_W, SETTLE_ICYC);
  localparam int MIN_GAP = guard_len(SYNC_STAGES, REARM_CYC) + 1;

  logic [15:0] busy_cnt;
  logic [7:0]  idle_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_cnt <= '0;
      idle_cnt <= 8'hFF;
    end else begin
      busy_cnt <= busy_n ? 16'd0 : busy_cnt + 16'd1;
      if (!busy_n)               idle_cnt <= '0;
      else if (idle_cnt != 8'hFF) idle_cnt <= idle_cnt + 8'd1;
    end
  end

  p_busy_len_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_n) |-> (int'(busy_cnt) == FRAME));

  p_hold_pos_r3: assert property (@(posedge clk) disable iff (rst)
    hold |-> (!busy_n && int'(busy_cnt) == HOLD_EDGE));

  p_hold_single_r3: assert property (@(posedge clk) disable iff (rst)
    hold |=> !hold);

  p_result_at_end_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(data) |-> $rose(busy_n));

  p_start_gap_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_n) |-> (int'(idle_cnt) >= MIN_GAP));

  p_dac_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (busy_n && $past(busy_n)) |-> $stable(dac_code));

  p_phase_stop_r9: assert property (@(posedge clk) disable iff (rst)
    (busy_n && $past(busy_n)) |-> !phase);

endmodule

bind sar_adc_ctl sar_adc_ctl_chk #(
  .DATA_W      (DATA_W),
  .SYNC_STAGES (SYNC_STAGES),
  .HOLD_EDGE   (HOLD_EDGE),
  .SETTLE_ICYC (SETTLE_ICYC),
  .REARM_CYC   (REARM_CYC)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .busy_n   (busy_n_o),
  .hold     (hold_o),
  .dac_code (dac_code_o),
  .data     (data_o),
  .phase    (div_phase)
);

// File: tb/sar_adc_ctl_tb_top.sv
`timescale 1ns/1ps
module sar_adc_ctl_tb_top;

  localparam int NVEC = 8;
  localparam logic [7:0] VEC [NVEC] = '{8'hA5, 8'h00, 8'hFF, 8'h80,
                                        8'h7F, 8'h01, 8'hFE, 8'h5A};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1;
  logic       rd_n = 1'b1;
  logic       cmp;
  logic       hold_o;
  logic [7:0] dac_code_o;
  logic       busy_n_o;
  logic [7:0] data_o;
  logic       data_oe_o;
  logic [7:0] ain = 8'h00;
  logic [7:0] held = 8'h00;
  int         tests = 0;
  int         fails = 0;
  bit         finished = 0;

  always #2 clk = ~clk;

  sar_adc_ctl dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .cmp_i(cmp),
    .hold_o(hold_o), .dac_code_o(dac_code_o), .busy_n_o(busy_n_o),
    .data_o(data_o), .data_oe_o(data_oe_o)
  );

  // Behavioural track/hold and comparator.
  always @(posedge clk) if (hold_o) held <= ain;
  assign cmp = (held >= dac_code_o);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic v);
    cs_n = v;
    rd_n = v;
  endtask

  task automatic run_conv(input logic [7:0] a0, input int chg_at, input logic [7:0] a1,
                          input int rel_at, output bit started, output logic [7:0] res,
                          output int blen, output int hidx, output logic [7:0] dac2,
                          output logic [7:0] dac4, output logic [7:0] mid_data,
                          output logic mid_oe);
    int idx;
    ain = a0; started = 0; res = '0; blen = 0; hidx = -1;
    dac2 = '0; dac4 = '0; mid_data = '0; mid_oe = 1'b0;
    for (int w = 0; w < 12; w++) begin
      @(negedge clk);
      if (!busy_n_o) begin started = 1; break; end
    end
    if (!started) return;
    idx = 0;
    while (!busy_n_o && idx < 100) begin
      if (hold_o && hidx < 0) hidx = idx;
      if (idx == 2)  dac2 = dac_code_o;
      if (idx == 4)  dac4 = dac_code_o;
      if (idx == 10) begin mid_data = data_o; mid_oe = data_oe_o; end
      if (idx == chg_at) ain = a1;
      if (idx == rel_at) strobe(1'b1);
      @(negedge clk);
      idx++;
    end
    blen = idx;
    res  = data_o;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual=0x0 expected=0x1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    bit         st;
    logic [7:0] res, d2, d4, md, prev, snap;
    logic       moe;
    int         bl, hi;
    bit         seen;

    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    check(busy_n_o == 1'b1,  "R10 busy_n", busy_n_o, 1);
    check(hold_o == 1'b0,    "R10 hold", hold_o, 0);
    check(data_oe_o == 1'b0, "R10 oe", data_oe_o, 0);
    check(dac_code_o == 8'h00 && data_o == 8'h00, "R10 dac/data",
          {dac_code_o, data_o}, 0);

    // Vector walk, slow-memory style: strobes held low across the frame.
    prev = 8'h00;
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk) strobe(1'b0);
      run_conv(VEC[v], -1, 8'h00, -1, st, res, bl, hi, d2, d4, md, moe);
      check(st == 1'b1,      "R1 start on read", int'(st), 1);
      check(res == VEC[v],   "R5 result code", res, VEC[v]);
      check(bl == 20,        "R2 busy length", bl, 20);
      check(hi == 3,         "R3 hold position", hi, 3);
      check(d2 == 8'h00,     "R4 cleared trial", d2, 0);
      check(d4 == 8'h80,     "R4 first trial MSB", d4, 8'h80);
      check(moe == 1'b1 && md == prev, "R7 old data during busy", md, prev);
      if (v == 0) begin
        seen = 0;
        repeat (8) begin
          @(negedge clk);
          if (!busy_n_o) seen = 1;
        end
        check(!seen, "R9 no restart while held low", int'(seen), 0);
        check(data_oe_o == 1'b1 && data_o == VEC[v], "R6 data driven", data_o, VEC[v]);
      end
      prev = res;
      strobe(1'b1);
      repeat (4) @(negedge clk);
      check(data_oe_o == 1'b0, "R6 oe released", data_oe_o, 0);
    end

    // Track before the hold edge, ignore after it.
    @(negedge clk) strobe(1'b0);
    run_conv(8'h33, 1, 8'hC4, 6, st, res, bl, hi, d2, d4, md, moe);
    check(res == 8'hC4, "R3 input tracked before hold", res, 8'hC4);
    repeat (6) @(negedge clk);
    @(negedge clk) strobe(1'b0);
    run_conv(8'h5A, 4, 8'h12, 6, st, res, bl, hi, d2, d4, md, moe);
    check(res == 8'h5A, "R3 input ignored after hold", res, 8'h5A);
    repeat (6) @(negedge clk);

    // Re-read inside the window after completion: data, no new frame.
    @(negedge clk) strobe(1'b0);
    run_conv(8'h3C, -1, 8'h00, 5, st, res, bl, hi, d2, d4, md, moe);
    strobe(1'b0);
    seen = 0;
    repeat (12) begin
      @(negedge clk);
      if (!busy_n_o) seen = 1;
    end
    check(!seen, "R8 re-read in window starts nothing", int'(seen), 0);
    check(data_oe_o == 1'b1 && data_o == 8'h3C, "R8 re-read returns new data", data_o, 8'h3C);
    strobe(1'b1);
    repeat (3) @(negedge clk);
    @(negedge clk) strobe(1'b0);
    run_conv(8'h81, -1, 8'h00, 5, st, res, bl, hi, d2, d4, md, moe);
    check(st == 1'b1 && res == 8'h81, "R8 later read starts conversion", res, 8'h81);

    // One clock past the window: must start.
    @(negedge clk) strobe(1'b0);
    run_conv(8'h4E, -1, 8'h00, 5, st, res, bl, hi, d2, d4, md, moe);
    check(st == 1'b1 && bl == 20, "R8 read just after window starts", bl, 20);
    check(res == 8'h4E, "R5 boundary result", res, 8'h4E);

    // Idle: trial code frozen, no hold strobe.
    repeat (2) @(negedge clk);
    snap = dac_code_o;
    seen = 0;
    repeat (10) begin
      @(negedge clk);
      if (dac_code_o != snap || hold_o) seen = 1;
    end
    check(!seen, "R9 idle outputs static", int'(seen), 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule